// File: doc/BRIEF.md
# Delay-Cycle Re-Arm Sequencer

This block closes out each delay cycle of a multi-channel delay generator and prepares the next one. A cycle starts in one of two ways. The first is the rising edge of an end-of-delay level, which reports that every channel has timed out. The second is a reload strobe from the processor, issued after new delay values have been written. Once started, the block plays a fixed timeline. A GATE window covers the whole cycle. Inside it sits a LOAD window, which the surrounding logic uses to preset its delay counters. A HOLD output keeps the channel outputs in their timed-out state, but only when the cycle was started by end-of-delay. A processor-started cycle leaves HOLD low.

Next to the sequencer, three status bits report the state of the delay machinery to the processor. BUSY is live. TRIGGERED and OVERRUN are sticky, and a flag-clear strobe removes them. If a set condition and the clear strobe land on the same cycle, the set wins.

With the default parameters and an 80 MHz clock, the timeline is 16 cycles of GATE alone, then 20 cycles of GATE with LOAD, then 28 cycles of GATE alone. That is 64 cycles, or 800 ns, in all.

Top module: `dly_rearm_seq`

## Requirements
- R1: Reset state. While `rst_n` is low, `gate_o`, `load_o`, `hold_o`, `triggered_o` and `overrun_o` are all 0.
- R2: A cycle starts when the block is idle and `eod_i` is sampled 1 at a clock edge after it was sampled 0 at the edge before. `gate_o` then rises after that edge and stays high for exactly PH_A+PH_B+PH_C cycles (64 by default).
- R3: Count cycle positions within a cycle from 0, where position 0 is the first cycle `gate_o` is high. `load_o` is high exactly at positions PH_A through PH_A+PH_B-1 (16..35 by default) and is low everywhere else.
- R4: A `reload_i` sampled 1 while the block is idle starts a cycle with the same GATE/LOAD timeline as R2 and R3.
- R5: `hold_o` is high at every position of a cycle started by end-of-delay and stays low throughout a cycle started by `reload_i`.
- R6: A start request (an `eod_i` rising edge or `reload_i`) sampled while `gate_o` is high has no effect. The running cycle keeps its length and its HOLD behaviour, and no second cycle follows it.
- R7: When a reload and an end-of-delay edge are sampled at the same edge while idle, the cycle is a reload cycle, so `hold_o` stays low.
- R8: `busy_o` equals `trig_latch_i` OR `gate_o`, combinationally.
- R9: `triggered_o` becomes 1 after any edge at which `busy_o` was 1. It then stays 1 until an edge where `flag_clr_i` is 1 and `busy_o` is 0.
- R10: `overrun_o` becomes 1 after any edge at which `trig_pulse_i` and `busy_o` were both 1. It then stays 1 until an edge where `flag_clr_i` is 1 and no new overrun is sampled.
- R11: When `flag_clr_i` and a set condition are sampled at the same edge, the flag ends up 1. When the clear arrives alone, the flag ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (80 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| eod_i | input | 1 | End-of-delay level: all channels timed out |
| trig_latch_i | input | 1 | Trigger latch level, feeds BUSY |
| trig_pulse_i | input | 1 | Single-cycle trigger event, feeds OVERRUN |
| reload_i | input | 1 | Processor reload strobe |
| flag_clr_i | input | 1 | Processor strobe clearing TRIGGERED and OVERRUN |
| gate_o | output | 1 | High for the whole re-arm cycle |
| load_o | output | 1 | Counter preset window inside GATE |
| hold_o | output | 1 | Keeps channel outputs timed out (end-of-delay cycles only) |
| busy_o | output | 1 | Trigger latch or cycle in progress |
| triggered_o | output | 1 | Sticky: BUSY seen since last clear |
| overrun_o | output | 1 | Sticky: trigger arrived while BUSY |

## Verification
The bench builds the block with its default phase lengths of 16, 20 and 28 cycles, so every phase boundary and the 64-cycle end of GATE are crossed many times within a short run. Because a full cycle is that short, random end-of-delay edges and reloads often arrive inside a running cycle, on its last cycle, and in the idle cycle right after it. Those cases exercise the ignore rule and the reload-over-end-of-delay priority. Random flag-clear strobes falling on the same cycle as BUSY or a trigger pulse bring the set-wins-over-clear rule within reach as well.

// File: rtl/dly_rearm_pkg.sv
package dly_rearm_pkg;

  typedef enum logic [1:0] {
    KICK_NONE = 2'd0,
    KICK_EOD  = 2'd1,
    KICK_CPU  = 2'd2
  } kick_t;

  // Total length of a re-arm cycle in clock cycles.
  function automatic int unsigned cycle_len(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
    return a + b + c;
  endfunction

  // True when position pos lies in the preset window [lo, lo+len).
  function automatic logic in_window(input int unsigned pos,
                                     input int unsigned lo,
                                     input int unsigned len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  // True when pos is the final position of a cycle of length total.
  function automatic logic is_last(input int unsigned pos,
                                   input int unsigned total);
    return pos == total - 1;
  endfunction

endpackage

// File: rtl/dly_rearm_kick.sv
module dly_rearm_kick
  import dly_rearm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  eod_i,
  input  logic  reload_i,
  input  logic  running_i,
  output logic  eod_edge_o,
  output kick_t kick_o
);

  logic eod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eod_q <= 1'b0;
    else        eod_q <= eod_i;
  end

  assign eod_edge_o = eod_i & ~eod_q;

  always_comb begin
    kick_o = KICK_NONE;
    if (!running_i) begin
      if (reload_i)        kick_o = KICK_CPU;
      else if (eod_edge_o) kick_o = KICK_EOD;
    end
  end

endmodule

// File: rtl/dly_rearm_timeline.sv
module dly_rearm_timeline
  import dly_rearm_pkg::*;
#(
  parameter int unsigned PH_A = 16,
  parameter int unsigned PH_B = 20,
  parameter int unsigned PH_C = 28,
  localparam int unsigned TOTAL = PH_A + PH_B + PH_C,
  localparam int unsigned CW = (TOTAL > 1) ? $clog2(TOTAL) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  kick_t         kick_i,
  output logic          running_o,
  output logic          cpu_cycle_o,
  output logic [CW-1:0] pos_o,
  output logic          last_o,
  output logic          load_win_o
);

  logic          run_q;
  logic          cpu_q;
  logic [CW-1:0] pos_q;

  assign last_o = run_q && is_last(int'(pos_q), cycle_len(PH_A, PH_B, PH_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cpu_q <= 1'b0;
      pos_q <= '0;
    end else if (run_q) begin
      if (last_o) begin
        run_q <= 1'b0;
        pos_q <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end else if (kick_i != KICK_NONE) begin
      run_q <= 1'b1;
      cpu_q <= (kick_i == KICK_CPU);
      pos_q <= '0;
    end
  end

  assign running_o   = run_q;
  assign cpu_cycle_o = cpu_q;
  assign pos_o       = pos_q;
  assign load_win_o  = run_q && in_window(int'(pos_q), PH_A, PH_B);

endmodule

// File: rtl/dly_rearm_flags.sv
module dly_rearm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic trig_pulse_i,
  input  logic flag_clr_i,
  output logic trg_set_o,
  output logic ovr_set_o,
  output logic triggered_o,
  output logic overrun_o
);

  logic trg_q, ovr_q;

  assign trg_set_o = busy_i;
  assign ovr_set_o = busy_i & trig_pulse_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      trg_q <= trg_set_o | (trg_q & ~flag_clr_i);
      ovr_q <= ovr_set_o | (ovr_q & ~flag_clr_i);
    end
  end

  assign triggered_o = trg_q;
  assign overrun_o   = ovr_q;

endmodule

// File: rtl/dly_rearm_seq.sv
module dly_rearm_seq
  import dly_rearm_pkg::*;
#(
  parameter int unsigned PH_A = 16,
  parameter int unsigned PH_B = 20,
  parameter int unsigned PH_C = 28,
  localparam int unsigned TOTAL = PH_A + PH_B + PH_C,
  localparam int unsigned CW = (TOTAL > 1) ? $clog2(TOTAL) : 1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic eod_i,
  input  logic trig_latch_i,
  input  logic trig_pulse_i,
  input  logic reload_i,
  input  logic flag_clr_i,
  output logic gate_o,
  output logic load_o,
  output logic hold_o,
  output logic busy_o,
  output logic triggered_o,
  output logic overrun_o
);

  // Named internal events, brought out for the checker.
  kick_t         kick;
  logic          eod_edge;
  logic          running;
  logic          cpu_cycle;
  logic [CW-1:0] pos;
  logic          last_pos;
  logic          load_win;
  logic          trg_set;
  logic          ovr_set;

  dly_rearm_kick u_kick (
    .clk        (clk),
    .rst_n      (rst_n),
    .eod_i      (eod_i),
    .reload_i   (reload_i),
    .running_i  (running),
    .eod_edge_o (eod_edge),
    .kick_o     (kick)
  );

  dly_rearm_timeline #(
    .PH_A (PH_A),
    .PH_B (PH_B),
    .PH_C (PH_C)
  ) u_timeline (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick_i      (kick),
    .running_o   (running),
    .cpu_cycle_o (cpu_cycle),
    .pos_o       (pos),
    .last_o      (last_pos),
    .load_win_o  (load_win)
  );

  assign gate_o = running;
  assign load_o = load_win;
  assign hold_o = running & ~cpu_cycle;
  assign busy_o = trig_latch_i | running;

  dly_rearm_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_o),
    .trig_pulse_i (trig_pulse_i),
    .flag_clr_i   (flag_clr_i),
    .trg_set_o    (trg_set),
    .ovr_set_o    (ovr_set),
    .triggered_o  (triggered_o),
    .overrun_o    (overrun_o)
  );

endmodule

// File: rtl/dly_rearm_seq_chk.sv
module dly_rearm_seq_chk #(
  parameter int unsigned PH_A = 16,
  parameter int unsigned PH_B = 20,
  parameter int unsigned PH_C = 28,
  localparam int unsigned TOTAL = PH_A + PH_B + PH_C,
  localparam int unsigned CW = (TOTAL > 1) ? $clog2(TOTAL) : 1
)(
  input logic          clk,
  input logic          rst_n,
  input logic          eod_i,
  input logic          reload_i,
  input logic          trig_latch_i,
  input logic          trig_pulse_i,
  input logic          flag_clr_i,
  input logic          gate_o,
  input logic          load_o,
  input logic          hold_o,
  input logic          busy_o,
  input logic          triggered_o,
  input logic          overrun_o,
  input logic [CW-1:0] pos
);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!gate_o && !load_o && !hold_o && !triggered_o && !overrun_o); // R1
    end
  end

  AST_EOD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    eod_i && !$past(eod_i) && !gate_o && !reload_i |=> gate_o && hold_o); // R2

  AST_GATE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> $past(pos) == CW'(TOTAL - 1)); // R2

  AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_o) |-> gate_o && pos == CW'(PH_A)); // R3

  AST_LOAD_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> gate_o); // R3

  AST_RELOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i && !gate_o |=> gate_o && !hold_o); // R4

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o && $past(gate_o) |-> hold_o == $past(hold_o)); // R5

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o && pos != CW'(TOTAL - 1) |=> gate_o); // R6

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o || trig_latch_i) |-> busy_o); // R8

  AST_TRG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || (triggered_o && !flag_clr_i)) |=> triggered_o); // R9

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse_i && busy_o |=> overrun_o); // R10

  AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_i && !busy_o |=> !triggered_o && !overrun_o); // R11

endmodule

bind dly_rearm_seq dly_rearm_seq_chk #(
  .PH_A (PH_A),
  .PH_B (PH_B),
  .PH_C (PH_C)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eod_i        (eod_i),
  .reload_i     (reload_i),
  .trig_latch_i (trig_latch_i),
  .trig_pulse_i (trig_pulse_i),
  .flag_clr_i   (flag_clr_i),
  .gate_o       (gate_o),
  .load_o       (load_o),
  .hold_o       (hold_o),
  .busy_o       (busy_o),
  .triggered_o  (triggered_o),
  .overrun_o    (overrun_o),
  .pos          (pos)
);

// File: tb/dly_rearm_seq_test.sv
module dly_rearm_seq_test;

  localparam int CLK_PERIOD = 12;
  localparam int A = 16;
  localparam int B = 20;
  localparam int C = 28;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eod = 1'b0, latch = 1'b0, tpulse = 1'b0, reload = 1'b0, fclr = 1'b0;
  logic gate, load, hold, busy, trg, ovr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // Reference model state.
  bit m_run, m_cpu, m_eodq, m_trg, m_ovr;
  int m_pos;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_rearm_seq #(.PH_A(A), .PH_B(B), .PH_C(C)) uut (
    .clk(clk), .rst_n(rst_n), .eod_i(eod), .trig_latch_i(latch),
    .trig_pulse_i(tpulse), .reload_i(reload), .flag_clr_i(fclr),
    .gate_o(gate), .load_o(load), .hold_o(hold), .busy_o(busy),
    .triggered_o(trg), .overrun_o(ovr)
  );

  function automatic bit exp_load(input bit run, input int p);
    return run && (p >= A) && (p <= A + B - 1);
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic chk_outputs();
    if (!rst_n) begin
      chk("R1", "gate", gate, 1'b0);
      chk("R1", "load", load, 1'b0);
      chk("R1", "hold", hold, 1'b0);
      chk("R1", "triggered", trg, 1'b0);
      chk("R1", "overrun", ovr, 1'b0);
    end else begin
      chk("R2", "gate", gate, m_run);
      chk("R3", "load", load, exp_load(m_run, m_pos));
      chk("R5", "hold", hold, m_run && !m_cpu);
      chk("R9", "triggered", trg, m_trg);
      chk("R10", "overrun", ovr, m_ovr);
    end
  endtask

  // Advance the model across one rising edge using the inputs now applied.
  task automatic model_edge();
    bit b, edge_e;
    b = latch | m_run;
    edge_e = eod & ~m_eodq;
    if (m_run) begin
      if (m_pos == A + B + C - 1) begin m_run = 0; m_pos = 0; end
      else m_pos++;
    end else if (reload) begin
      m_run = 1; m_pos = 0; m_cpu = 1;
    end else if (edge_e) begin
      m_run = 1; m_pos = 0; m_cpu = 0;
    end
    m_eodq = eod;
    m_trg = b | (m_trg & ~fclr);
    m_ovr = (tpulse & b) | (m_ovr & ~fclr);
  endtask

  // One cycle: check registered outputs, apply inputs, check BUSY, clock.
  task automatic step(input bit e, input bit l, input bit tp, input bit rl, input bit fc);
    @(negedge clk);
    chk_outputs();
    eod = e; latch = l; tpulse = tp; reload = rl; fclr = fc;
    #1;
    chk("R8", "busy", busy, l | m_run);
    model_edge();
  endtask

  task automatic idle(input int n, input bit e);
    for (int i = 0; i < n; i++) step(e, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk_outputs();
    @(negedge clk);
    rst_n = 1'b1;
    m_run = 0; m_cpu = 0; m_eodq = 0; m_trg = 0; m_ovr = 0; m_pos = 0;

    // R2 R3 R5: end-of-delay cycle; eod held high must not restart (R6)
    idle(2, 0);
    idle(80, 1);
    step(0, 0, 0, 0, 0);
    chk("R6", "gate idle after held eod", gate, 1'b0);
    step(0, 0, 0, 0, 1);   // clear flags alone (R11)
    idle(2, 0);
    chk("R11", "triggered cleared", trg, 1'b0);

    // R4: reload cycle, hold stays low
    step(0, 0, 0, 1, 0);
    idle(10, 0);
    chk("R4", "gate during reload cycle", gate, 1'b1);
    chk("R5", "hold low in reload cycle", hold, 1'b0);
    // R6: requests during a running cycle
    step(1, 0, 0, 1, 0);
    idle(60, 0);

    // R7: both on the same edge while idle
    step(1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    chk("R7", "reload wins, hold low", hold, 1'b0);
    chk("R7", "gate", gate, 1'b1);
    idle(70, 0);

    // R10 R11: trigger pulse while busy together with clear -> set wins
    step(0, 1, 1, 0, 1);
    step(0, 0, 0, 0, 0);
    chk("R11", "overrun set wins", ovr, 1'b1);
    chk("R11", "triggered set wins", trg, 1'b1);
    // R10: trigger pulse while not busy does not set overrun
    step(0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R10", "no overrun when idle", ovr, 1'b0);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      bit e, l, tp, rl, fc;
      e  = ($urandom % 8) < 3;
      l  = ($urandom % 10) == 0;
      tp = ($urandom % 12) == 0;
      rl = ($urandom % 90) == 0;
      fc = ($urandom % 15) == 0;
      step(e, l, tp, rl, fc);
    end
    idle(70, 0);
    @(negedge clk);
    chk_outputs();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule